// File: doc/BRIEF.md
# Vector ALU Issue Queue with Subunit Routing

This block holds vector operations that wait for their source operands before they go to a vector ALU. The ALU is made of three subunits: simple integer, complex integer and floating-point. The storage is split into four banks of five entries, one bank per non-branch dispatch slot. The selector treats all twenty entries as one queue. In any cycle at most two operations arrive, and the lower slot number is the older operation. Each cycle the oldest entry whose two sources are both ready leaves the queue. It goes to the subunit named by its 2-bit class, and the issue port carries a one-hot subunit select.

Every issued destination tag goes into a delay line for its subunit. The tag comes back on an internal wakeup bus timed so that a dependent entry in this queue can issue exactly the subunit latency after its producer. The same tag appears one cycle later on a second bus meant for a permute-side queue, because a permute consumer needs one extra cycle. Result tags from outside the block arrive on an external wake input. Operand data, register storage and the subunit datapaths are not part of this block.

Top module: `vec_alu_issue_q`

## Requirements
- R1: While reset is held and in the first cycle after it, no issue, stall, wake or permute-wake output is active.
- R2: An op on slot i is written into bank i. `disp_stall` is high in any cycle where a valid slot's bank already holds five entries. A stalled cycle writes no op at all, and a full bank does not block a slot whose own bank has room.
- R3: At most two of the four `disp_vld` bits are high in one cycle. Among ops entering together, the lower slot number is the older op.
- R4: An entry may issue only when both of its source ready bits are set. A source becomes ready in one of three ways: its ready flag is set at dispatch, its tag matches the external wake bus, or its tag matches an internal wake bus. A match in the same cycle as the dispatch also counts.
- R5: Each cycle, the oldest eligible entry across all four banks issues, and no more than one entry issues per cycle.
- R6: `iss_sel` is one-hot. Class 0 sets bit 0 (simple integer), class 1 sets bit 1 (complex integer) and class 2 sets bit 2 (floating-point). Class 3 is illegal.
- R7: Take a producer issued in cycle t whose result is the only missing source of a dependent. The dependent issues in cycle t+L, where L is 2, 5 or 8 for the simple, complex and floating-point subunits, and not before.
- R8: Internal wake lane u (u = class code) carries the issued destination tag in cycle t+L-1.
- R9: Permute wake lane u carries the same tag in cycle t+L, one cycle after lane u of the internal bus.
- R10: An op that is ready at dispatch issues no earlier than the cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_vld | input | 4 | Per-slot dispatch valid |
| disp_src0 | input | 4*TAGW | Per-slot first source tag |
| disp_rdy0 | input | 4 | Per-slot first source ready at dispatch |
| disp_src1 | input | 4*TAGW | Per-slot second source tag |
| disp_rdy1 | input | 4 | Per-slot second source ready at dispatch |
| disp_dst | input | 4*TAGW | Per-slot destination tag |
| disp_cls | input | 8 | Per-slot subunit class, 2 bits each |
| disp_stall | output | 1 | Dispatch refused this cycle |
| ext_wake_vld | input | 1 | External result tag valid |
| ext_wake_tag | input | TAGW | External result tag |
| iss_vld | output | 1 | An op issues this cycle |
| iss_sel | output | 3 | One-hot subunit select |
| iss_dst | output | TAGW | Destination tag of the issued op |
| wake_vld | output | 3 | Internal wake valid per subunit |
| wake_tag | output | 3*TAGW | Internal wake tag per subunit |
| pwake_vld | output | 3 | Permute-consumer wake valid per subunit |
| pwake_tag | output | 3*TAGW | Permute-consumer wake tag per subunit |

## Verification
The hardest case to create from the ports is the age-order pick across banks while entries are leaving and new ones are arriving in the same cycle. The stimulus holds four ops in four different banks, all waiting on one tag, with the dispatch slots deliberately out of program order across two cycles. It then releases them all with a single external wake. While they drain, a fresh ready op arrives, and the bench checks that it issues strictly after the four parked ones. Each latency is measured by a producer-consumer pair per subunit, with the issue port and both wake buses checked in every cycle of the window.

// File: rtl/vec_alu_issue_q.sv
module vec_alu_issue_q #(
  parameter int TAGW   = 6,
  parameter int DEPTH  = 5,
  parameter int LAT_SI = 2,
  parameter int LAT_CI = 5,
  parameter int LAT_FP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          disp_vld,
  input  logic [4*TAGW-1:0]   disp_src0,
  input  logic [3:0]          disp_rdy0,
  input  logic [4*TAGW-1:0]   disp_src1,
  input  logic [3:0]          disp_rdy1,
  input  logic [4*TAGW-1:0]   disp_dst,
  input  logic [7:0]          disp_cls,
  output logic                disp_stall,
  input  logic                ext_wake_vld,
  input  logic [TAGW-1:0]     ext_wake_tag,
  output logic                iss_vld,
  output logic [2:0]          iss_sel,
  output logic [TAGW-1:0]     iss_dst,
  output logic [2:0]          wake_vld,
  output logic [3*TAGW-1:0]   wake_tag,
  output logic [2:0]          pwake_vld,
  output logic [3*TAGW-1:0]   pwake_tag
);
  localparam int NB = 4;
  localparam int N  = NB * DEPTH;
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);
  localparam int DW = $clog2(DEPTH);

  logic [N-1:0]          ev, er0, er1;
  logic [CW-1:0]         ea  [N];
  logic [TAGW-1:0]       es0 [N];
  logic [TAGW-1:0]       es1 [N];
  logic [TAGW-1:0]       ed  [N];
  logic [1:0]            ec  [N];
  logic [CW-1:0]         ent_cnt;
  logic [NB-1:0]         bank_full;
  logic [DW-1:0]         free_idx [NB];
  logic [CW-1:0]         new_age  [NB];
  logic                  found;
  logic [IW-1:0]         sel_idx;
  logic [CW-1:0]         best_age;
  logic [3:0]            hv;
  logic [3:0][TAGW-1:0]  ht;

  function automatic logic hit(input logic [3:0] v, input logic [3:0][TAGW-1:0] t,
                               input logic [TAGW-1:0] x);
    logic h = 1'b0;
    for (int i = 0; i < 4; i++) h |= v[i] && (t[i] == x);
    return h;
  endfunction

  assign ent_cnt = CW'($countones(ev));
  assign hv = {ext_wake_vld, wake_vld};
  assign ht = {ext_wake_tag, wake_tag};

  always_comb begin
    logic [CW-1:0] off;
    off = ent_cnt - CW'(iss_vld);
    for (int b = 0; b < NB; b++) begin
      bank_full[b] = 1'b1;
      free_idx[b]  = '0;
      for (int k = DEPTH - 1; k >= 0; k--)
        if (!ev[b*DEPTH+k]) begin
          bank_full[b] = 1'b0;
          free_idx[b]  = DW'(k);
        end
      new_age[b] = off;
      if (disp_vld[b]) off = off + 1'b1;
    end
  end

  assign disp_stall = |(disp_vld & bank_full);

  always_comb begin
    found    = 1'b0;
    sel_idx  = '0;
    best_age = '1;
    for (int e = 0; e < N; e++)
      if (ev[e] && er0[e] && er1[e] && (!found || ea[e] < best_age)) begin
        found    = 1'b1;
        sel_idx  = IW'(e);
        best_age = ea[e];
      end
  end

  assign iss_vld = found;
  assign iss_dst = ed[sel_idx];
  assign iss_sel = found ? (3'b001 << ec[sel_idx]) : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= '0;
    end else begin
      for (int e = 0; e < N; e++)
        if (ev[e]) begin
          if (iss_vld && sel_idx == IW'(e)) begin
            ev[e] <= 1'b0;
          end else begin
            if (iss_vld && ea[e] > best_age) ea[e] <= ea[e] - 1'b1;
            if (hit(hv, ht, es0[e])) er0[e] <= 1'b1;
            if (hit(hv, ht, es1[e])) er1[e] <= 1'b1;
          end
        end
      for (int b = 0; b < NB; b++)
        if (disp_vld[b] && !disp_stall) begin
          ev [b*DEPTH + int'(free_idx[b])] <= 1'b1;
          ea [b*DEPTH + int'(free_idx[b])] <= new_age[b];
          es0[b*DEPTH + int'(free_idx[b])] <= disp_src0[b*TAGW +: TAGW];
          es1[b*DEPTH + int'(free_idx[b])] <= disp_src1[b*TAGW +: TAGW];
          ed [b*DEPTH + int'(free_idx[b])] <= disp_dst[b*TAGW +: TAGW];
          ec [b*DEPTH + int'(free_idx[b])] <= disp_cls[2*b +: 2];
          er0[b*DEPTH + int'(free_idx[b])] <= disp_rdy0[b] | hit(hv, ht, disp_src0[b*TAGW +: TAGW]);
          er1[b*DEPTH + int'(free_idx[b])] <= disp_rdy1[b] | hit(hv, ht, disp_src1[b*TAGW +: TAGW]);
        end
    end
  end

  for (genvar u = 0; u < 3; u++) begin : g_lane
    localparam int L = (u == 0) ? LAT_SI : (u == 1) ? LAT_CI : LAT_FP;
    logic [L-1:0]           dv;
    logic [L-1:0][TAGW-1:0] dt;
    always_ff @(posedge clk) begin
      if (!rst_n) dv <= '0;
      else        dv <= {dv[L-2:0], iss_vld & iss_sel[u]};
      dt <= {dt[L-2:0], iss_dst};
    end
    assign wake_vld[u]               = dv[L-2];
    assign wake_tag[u*TAGW +: TAGW]  = dt[L-2];
    assign pwake_vld[u]              = dv[L-1];
    assign pwake_tag[u*TAGW +: TAGW] = dt[L-1];
  end
endmodule

// File: rtl/vec_alu_issue_q_chk.sv
module vec_alu_issue_q_chk #(
  parameter int TAGW = 6,
  parameter int CW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        disp_vld,
  input logic              disp_stall,
  input logic              iss_vld,
  input logic [2:0]        iss_sel,
  input logic [TAGW-1:0]   iss_dst,
  input logic [2:0]        wake_vld,
  input logic [3*TAGW-1:0] wake_tag,
  input logic [2:0]        pwake_vld,
  input logic [3*TAGW-1:0] pwake_tag,
  input logic [CW-1:0]     ent_cnt
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !iss_vld && pwake_vld == 3'b000);

  p_stall_no_write_r2: assert property (@(posedge clk) disp_stall |=> ent_cnt <= $past(ent_cnt));

  p_two_max_r3: assert property (@(posedge clk) disable iff (!rst_n) $countones(disp_vld) <= 2);

  p_no_issue_empty_r5: assert property (@(posedge clk) disable iff (!rst_n) ent_cnt == '0 |-> !iss_vld);

  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n) iss_vld |-> $countones(iss_sel) == 1);

  p_si_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld && iss_sel[0] |=> wake_vld[0] && wake_tag[TAGW-1:0] == $past(iss_dst));

  for (genvar u = 0; u < 3; u++) begin : g_p
    p_perm_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vld[u] |=> pwake_vld[u] && pwake_tag[u*TAGW +: TAGW] == $past(wake_tag[u*TAGW +: TAGW]));
  end
endmodule

bind vec_alu_issue_q vec_alu_issue_q_chk #(.TAGW(TAGW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_stall(disp_stall),
  .iss_vld(iss_vld), .iss_sel(iss_sel), .iss_dst(iss_dst),
  .wake_vld(wake_vld), .wake_tag(wake_tag), .pwake_vld(pwake_vld),
  .pwake_tag(pwake_tag), .ent_cnt(ent_cnt));

// File: tb/vec_alu_issue_q_tb_top.sv
module vec_alu_issue_q_tb_top;
  localparam int TAGW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] disp_vld, disp_rdy0, disp_rdy1;
  logic [4*TAGW-1:0] disp_src0, disp_src1, disp_dst;
  logic [7:0] disp_cls;
  logic disp_stall, ext_wake_vld, iss_vld;
  logic [TAGW-1:0] ext_wake_tag, iss_dst;
  logic [2:0] iss_sel, wake_vld, pwake_vld;
  logic [3*TAGW-1:0] wake_tag, pwake_tag;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  vec_alu_issue_q dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    disp_vld = '0; disp_rdy0 = '0; disp_rdy1 = '0;
    disp_src0 = '0; disp_src1 = '0; disp_dst = '0; disp_cls = '0;
    ext_wake_vld = 1'b0; ext_wake_tag = '0;
  endtask

  task automatic nxt();
    @(posedge clk); #1; clr();
  endtask

  task automatic put(input int s, input int s0, input bit r0, input int s1, input bit r1,
                     input int d, input int c);
    disp_vld[s] = 1'b1;
    disp_src0[s*TAGW +: TAGW] = TAGW'(s0); disp_rdy0[s] = r0;
    disp_src1[s*TAGW +: TAGW] = TAGW'(s1); disp_rdy1[s] = r1;
    disp_dst[s*TAGW +: TAGW] = TAGW'(d);   disp_cls[2*s +: 2] = 2'(c);
  endtask

  task automatic wake(input int t);
    ext_wake_vld = 1'b1; ext_wake_tag = TAGW'(t);
  endtask

  task automatic see_iss(input string req, input bit v, input int d);
    @(negedge clk);
    chk(iss_vld == v, req, int'(iss_vld), int'(v));
    if (v) chk(iss_dst == TAGW'(d), req, int'(iss_dst), d);
  endtask

  initial begin
    clr();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!iss_vld && !disp_stall, "R1 issue/stall in reset", int'(iss_vld), 0);
    chk(wake_vld == 0 && pwake_vld == 0, "R1 wake in reset", int'(pwake_vld), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!iss_vld && wake_vld == 0 && pwake_vld == 0, "R1 after reset", int'(iss_vld), 0);

    // R10: ready op issues in the cycle after dispatch, not the same one
    nxt(); put(0, 1, 1, 2, 1, 5, 0);
    see_iss("R10 same cycle", 1'b0, 0);
    nxt(); see_iss("R10 next cycle", 1'b1, 5);
    repeat (4) nxt();

    // R6/R7/R8/R9: latency per subunit with a simple-integer consumer
    for (int c = 0; c < 3; c++) begin
      int L;
      L = (c == 0) ? 2 : (c == 1) ? 5 : 8;
      put(0, 1, 1, 2, 1, 10, c);
      put(1, 10, 0, 3, 1, 11, 0);
      nxt();
      see_iss("R7 producer issue", 1'b1, 10);
      chk(iss_sel == (3'b001 << c), "R6 subunit select", int'(iss_sel), 1 << c);
      for (int k = 1; k <= L; k++) begin
        nxt();
        see_iss("R7 consumer timing", k == L, 11);
        chk(wake_vld[c] == (k == L - 1), "R8 wake cycle", int'(wake_vld[c]), int'(k == L - 1));
        if (k == L - 1) chk(wake_tag[c*TAGW +: TAGW] == 10, "R8 wake tag",
                            int'(wake_tag[c*TAGW +: TAGW]), 10);
        chk(pwake_vld[c] == (k == L), "R9 permute wake cycle", int'(pwake_vld[c]), int'(k == L));
        if (k == L) chk(pwake_tag[c*TAGW +: TAGW] == 10, "R9 permute wake tag",
                        int'(pwake_tag[c*TAGW +: TAGW]), 10);
      end
      repeat (10) nxt();
    end

    // R3/R5: age order across banks, slots out of order, insert while draining
    put(3, 50, 0, 1, 1, 21, 0); put(1, 50, 0, 1, 1, 20, 0);
    nxt(); put(2, 50, 0, 1, 1, 23, 0); put(0, 50, 0, 1, 1, 22, 0);
    nxt(); wake(50);
    see_iss("R4 not yet ready", 1'b0, 0);
    nxt(); see_iss("R5 order 1", 1'b1, 20);
    nxt(); put(3, 1, 1, 1, 1, 24, 0);
    see_iss("R3 lower slot older", 1'b1, 21);
    nxt(); see_iss("R5 order 3", 1'b1, 22);
    nxt(); see_iss("R5 order 4", 1'b1, 23);
    nxt(); see_iss("R5 newest last", 1'b1, 24);
    nxt(); see_iss("R5 drained", 1'b0, 0);
    repeat (4) nxt();

    // R2: fill bank 0, stall, other bank independent
    for (int i = 0; i < 5; i++) begin
      put(0, 60, 0, 1, 1, 30 + i, 0);
      nxt();
    end
    put(0, 60, 0, 1, 1, 35, 0); put(1, 1, 1, 1, 1, 36, 0);
    @(negedge clk); chk(disp_stall, "R2 stall on full bank", int'(disp_stall), 1);
    nxt(); put(1, 1, 1, 1, 1, 37, 0);
    @(negedge clk); chk(!disp_stall, "R2 other bank free", int'(disp_stall), 0);
    chk(!iss_vld, "R2 stalled op not written", int'(iss_vld), 0);
    nxt(); see_iss("R2 other bank op", 1'b1, 37);
    nxt(); wake(60);
    for (int i = 0; i < 5; i++) begin
      nxt(); see_iss("R2 bank drain", 1'b1, 30 + i);
    end
    nxt(); see_iss("R2 no sixth entry", 1'b0, 0);
    repeat (3) nxt();

    // R4: wake in dispatch cycle, and two sources
    put(2, 70, 0, 1, 1, 40, 0); wake(70);
    nxt(); see_iss("R4 same-cycle wake", 1'b1, 40);
    nxt(); put(1, 71, 0, 72, 0, 41, 1);
    nxt(); wake(71);
    see_iss("R4 none ready", 1'b0, 0);
    nxt(); wake(72);
    see_iss("R4 one source only", 1'b0, 0);
    nxt(); see_iss("R4 both ready", 1'b1, 41);
    repeat (10) nxt();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule